// File: doc/BRIEF.md
# Banked GPIO Data Register File

This block holds the per-pin state of a general-purpose I/O controller with up to five banks of 32 pins. A 32-bit register bus reaches each bank through a small window of words. Software selects the direction of each pin and holds an output level for it. It changes individual output levels through write-one-to-set and write-one-to-clear words, so no read-modify-write sequence is needed. It reads back the pad level through a two-flop synchronizer.

The block drives an output-enable vector and an output-value vector toward the pads and samples a pad input vector. The bus is a plain register port with no handshake. A write takes effect at the clock edge where the write strobe is high. A read is combinational from the address. Bank windows begin at byte offset 0x10 and repeat every 0x28 bytes. The words of a bank that are not used here stay unmapped, so a neighbouring block can own them.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every direction bit is 1, so every pin is an input and `pad_oe` is all zero. Every output latch is 0, so `pad_out` is all zero.
- R2: Bank b (0 to NUM_BANKS-1) occupies byte address 0x10 + 0x28*b. Within a bank the words sit at these byte offsets: +0x00 direction, +0x04 output latch, +0x08 set port, +0x0C clear port, +0x10 input level.
- R3: A direction bit of 1 makes that pin an input (`pad_oe` bit 0). A direction bit of 0 makes it an output (`pad_oe` bit 1). The direction word reads back as written.
- R4: A write to the output-latch word replaces the whole latch. The new value appears on `pad_out` after that clock edge and reads back from the same word.
- R5: A write to the set port sets the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R6: A write to the clear port clears the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R7: The input-level word returns the pad level after two clock edges, whatever the pin's direction. A read after only one edge still returns the old level.
- R8: The following addresses read as zero: the set and clear ports; addresses below the first bank; window words past +0x10; addresses beyond the last bank; and addresses that are not a multiple of 4. A write to any of these changes no direction or latch bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and synchronizer |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_BANKS*32 (160) | Pad levels, asynchronous to clk |
| pad_oe | output | NUM_BANKS*32 (160) | Per-pin output enable, 1 drives the pad |
| pad_out | output | NUM_BANKS*32 (160) | Per-pin output level from the latch |

## Verification
The assertions assume that reset is held for at least one clock edge before the block is used. They also assume that the bus presents one address per cycle, so that at most one bank receives a strobe at each edge. The synchronizer check further assumes that `pad_in` is stable at each sampling edge. The stimulus changes the bus signals and `pad_in` only on falling edges. It keeps the write strobe low through reset. It waits at least two edges after reset before it compares any input-level word.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned WORD_BYTES     = WORD_W / 8;
  localparam int unsigned WORDS_PER_BANK = 5;

  typedef enum logic [2:0] {
    WK_DIR = 3'd0,
    WK_OUT = 3'd1,
    WK_SET = 3'd2,
    WK_CLR = 3'd3,
    WK_IN  = 3'd4
  } word_kind_e;
endpackage

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
  import gpio_rf_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_BANKS   = 5,
  parameter int unsigned BANK_BASE   = 16,
  parameter int unsigned BANK_STRIDE = 40,
  parameter int unsigned BIDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BIDX_W-1:0] bank_idx,
  output word_kind_e        kind
);
  localparam int unsigned SPAN = BANK_STRIDE * NUM_BANKS;
  localparam int unsigned USED = WORDS_PER_BANK * WORD_BYTES;

  logic [31:0] abs_a, rel_a, bsel, woff;

  always_comb begin
    abs_a    = 32'(addr);
    rel_a    = abs_a - 32'(BANK_BASE);
    bsel     = rel_a / 32'(BANK_STRIDE);
    woff     = rel_a - bsel * 32'(BANK_STRIDE);
    hit      = (abs_a >= 32'(BANK_BASE)) && (rel_a < 32'(SPAN)) &&
               (woff < 32'(USED)) && (woff[1:0] == 2'b00);
    bank_idx = BIDX_W'(bsel);
    kind     = word_kind_e'(3'(woff >> 2));
  end
endmodule

// File: rtl/gpio_rf_bank.sv
module gpio_rf_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         out_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (out_we) out_q <= wdata;
      else        out_q <= (out_q & ~clr_mask) | set_mask;
    end
  end

  p_set_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |=> ((out_q & $past(set_mask)) == $past(set_mask)));

  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |=> ((out_q & $past(clr_mask & ~set_mask)) == '0));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_we && set_mask == '0 && clr_mask == '0) |=> $stable(out_q));

  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1;
  logic [1:0]   warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      sync_o <= '0;
      warm   <= '0;
    end else begin
      stage1 <= pad_i;
      sync_o <= stage1;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  p_two_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (sync_o == $past(pad_i, 2)));
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_rf_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 5,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BANK_BASE   = 16,
  parameter int unsigned BANK_STRIDE = 40,
  localparam int unsigned NP         = NUM_BANKS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NP-1:0]     pad_in,
  output logic [NP-1:0]     pad_oe,
  output logic [NP-1:0]     pad_out
);
  localparam int unsigned BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              hit;
  logic [BIDX_W-1:0] bank_idx;
  word_kind_e        kind;

  logic [WORD_W-1:0] dir_arr [NUM_BANKS];
  logic [WORD_W-1:0] out_arr [NUM_BANKS];
  logic [WORD_W-1:0] in_arr  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_touch;

  gpio_rf_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_BASE(BANK_BASE),
    .BANK_STRIDE(BANK_STRIDE), .BIDX_W(BIDX_W)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .bank_idx(bank_idx), .kind(kind)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              sel;
    logic              dir_we, out_we;
    logic [WORD_W-1:0] set_m, clr_m;

    assign sel    = bus_we && hit && (bank_idx == BIDX_W'(b));
    assign dir_we = sel && (kind == WK_DIR);
    assign out_we = sel && (kind == WK_OUT);
    assign set_m  = (sel && kind == WK_SET) ? bus_wdata : '0;
    assign clr_m  = (sel && kind == WK_CLR) ? bus_wdata : '0;
    assign bank_touch[b] = dir_we | out_we | (set_m != '0) | (clr_m != '0);

    gpio_rf_bank #(.W(WORD_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .out_we(out_we),
      .wdata(bus_wdata), .set_mask(set_m), .clr_mask(clr_m),
      .dir_q(dir_arr[b]), .out_q(out_arr[b])
    );

    gpio_in_sync #(.W(WORD_W)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .pad_i(pad_in[b*WORD_W +: WORD_W]), .sync_o(in_arr[b])
    );

    assign pad_oe[b*WORD_W +: WORD_W]  = ~dir_arr[b];
    assign pad_out[b*WORD_W +: WORD_W] = out_arr[b];
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit && bank_idx == BIDX_W'(b)) begin
        case (kind)
          WK_DIR:  bus_rdata = dir_arr[b];
          WK_OUT:  bus_rdata = out_arr[b];
          WK_IN:   bus_rdata = in_arr[b];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  p_single_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_touch));

  p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0));

  p_no_decode_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: tb/gpio_bank_regfile_test.sv
`timescale 1ns/1ps
module gpio_bank_regfile_test;
  localparam int NB = 5;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] m_dir [NB];
  logic [31:0] m_out [NB];

  always #4 clk = ~clk;

  gpio_bank_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] waddr(input int b, input int w);
    return 8'(16 + 40 * b + 4 * w);
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    int rel, b, w;
    if (a < 16 || a >= 16 + 40 * NB) return '0;
    rel = a - 16; b = rel / 40; w = rel % 40;
    if (w >= 20 || (w % 4) != 0) return '0;
    case (w / 4)
      0: return m_dir[b];
      1: return m_out[b];
      4: return pad_in[b*32 +: 32];
      default: return '0;
    endcase
  endfunction

  task automatic sweep(input string req);
    logic [31:0] d;
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      chk(req, d, exp_read(a));
    end
  endtask

  task automatic pads_check(input string req);
    for (int b = 0; b < NB; b++) begin
      chk(req, pad_oe[b*32 +: 32], ~m_dir[b]);
      chk(req, pad_out[b*32 +: 32], m_out[b]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    for (int b = 0; b < NB; b++) begin
      m_dir[b] = '1; m_out[b] = '0;
      pad_in[b*32 +: 32] = 32'h1357_9BDF ^ (32'(b) * 32'h0101_0101);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state, R2/R8 full map after reset
    pads_check("R1");
    sweep("R2");

    for (int b = 0; b < NB; b++) begin
      // R3 direction
      v = 32'hA5A5_0F0F ^ (32'(b) * 32'h1111_1111);
      wr(waddr(b, 0), v); m_dir[b] = v;
      rd(waddr(b, 0), d); chk("R3", d, v);
      chk("R3", pad_oe[b*32 +: 32], ~v);
      // R4 whole-latch write
      v = 32'h6C3A_91E4 + 32'(b) * 32'h0F1E_2D3C;
      wr(waddr(b, 1), v); m_out[b] = v;
      chk("R4", pad_out[b*32 +: 32], v);
      rd(waddr(b, 1), d); chk("R4", d, v);
      // R5 set port
      v = 32'h0000_FFFF << b;
      wr(waddr(b, 2), v); m_out[b] = m_out[b] | v;
      chk("R5", pad_out[b*32 +: 32], m_out[b]);
      rd(waddr(b, 1), d); chk("R5", d, m_out[b]);
      // R6 clear port
      v = 32'hF0F0_3C3C >> b;
      wr(waddr(b, 3), v); m_out[b] = m_out[b] & ~v;
      chk("R6", pad_out[b*32 +: 32], m_out[b]);
      rd(waddr(b, 1), d); chk("R6", d, m_out[b]);
      // R5/R6 zero masks change nothing
      wr(waddr(b, 2), 32'h0); wr(waddr(b, 3), 32'h0);
      chk("R5", pad_out[b*32 +: 32], m_out[b]);
    end
    pads_check("R3");

    // R8 writes to unmapped addresses leave everything unchanged
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0);
    wr(8'h24, 32'h0);
    wr(8'h12, 32'h0);
    wr(8'h39, 32'hFFFF_FFFF);
    wr(8'hD8, 32'h0);
    wr(8'hFC, 32'hFFFF_FFFF);
    pads_check("R8");
    sweep("R8");

    // R7 two-edge latency on an output pin
    wr(waddr(2, 0), 32'h0); m_dir[2] = 32'h0;
    v = pad_in[64 +: 32];
    @(negedge clk);
    pad_in[64 +: 32] = ~v;
    rd(waddr(2, 4), d); chk("R7", d, v);
    @(negedge clk);
    rd(waddr(2, 4), d); chk("R7", d, v);
    @(negedge clk);
    rd(waddr(2, 4), d); chk("R7", d, ~v);
    sweep("R7");

    // R1 reset again restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_out[b] = '0; end
    pads_check("R1");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule